// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It holds the four arithmetic status flags (negative, zero, carry, overflow) in a small register file. The execute stage writes them with a per-flag write mask, so an instruction that changes only some flags leaves the others alone. A branch request carries a 4-bit condition code. The block evaluates that code against the newest flag values and returns a registered taken decision one cycle after the request.

When a flag write and a branch request arrive in the same cycle, the written flag values reach the evaluator through a bypass. The branch therefore sees the result of the instruction just ahead of it, with no stall. The full set of signed and unsigned comparisons is supported, including the compound conditions that combine the carry or sign/overflow test with the zero flag. One code is always taken and one is never taken.

Top module: `branch_resolver`

## Requirements
- R1: An active-low asynchronous reset clears all four stored flags to zero and drives `takenValid` and `taken` low. After reset, and before any flag write, a branch with code 0000 is not taken and a branch with code 0001 is taken.
- R2: `takenValid` is high in the cycle after each cycle with `brValid` high, and low otherwise. `taken` is low whenever `takenValid` is low.
- R3: Flag bits are `flagIn[3]`=N, `flagIn[2]`=Z, `flagIn[1]`=C and `flagIn[0]`=V, with the same positions in `flagWe`. A stored flag takes the value of `flagIn` at a clock edge only if its `flagWe` bit is set. Otherwise it keeps its value, including across cycles with a branch but no write.
- R4: When `brValid` and `flagWe` bits are high in the same cycle, the branch is evaluated with the newly written values for the masked flags and the stored values for the rest.
- R5: Code 0000 (equal) is taken when Z=1. Code 0001 (not equal) is taken when Z=0.
- R6: Code 0010 is taken when C=1 and code 0011 when C=0. Code 0100 is taken when N=1 and code 0101 (positive or zero) when N=0. Code 0110 is taken when V=1 and code 0111 when V=0.
- R7: Code 1000 (unsigned higher) is taken when C=1 and Z=0. Code 1001 (lower or same) is taken when C=0 or Z=1.
- R8: Code 1010 (signed greater or equal) is taken when N equals V. Code 1011 (signed less than) is taken when N differs from V.
- R9: Code 1100 (signed greater than) is taken when Z=0 and N equals V. Code 1101 (signed less or equal) is taken when Z=1 or N differs from V.
- R10: Code 1110 is always taken. Code 1111 is never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flagWe | input | 4 | Per-flag write mask (N,Z,C,V from bit 3 down) |
| flagIn | input | 4 | New flag values from execute |
| brValid | input | 1 | Branch request this cycle |
| brCond | input | 4 | Condition code of the request |
| takenValid | output | 1 | Decision valid, one cycle after the request |
| taken | output | 1 | Branch taken decision |

## Verification
A stored flag with a wrong value stays invisible until a branch tests that flag. It then shows up as a wrong `taken` one cycle after that request. For this reason the sweep writes every flag combination and follows it with every condition code, both through the stored path and through the bypass. A broken write mask or bypass leaves a stale bit that the next branch testing that bit exposes. Random partial-mask traffic catches flags that are held or overwritten in error. A fault in the valid pipeline shows on `takenValid` within one cycle of any request.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int FLAG_W = 4;
  localparam int COND_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [COND_W-1:0] {
    CondZeroSet   = 4'h0,
    CondZeroClr   = 4'h1,
    CondCarrySet  = 4'h2,
    CondCarryClr  = 4'h3,
    CondNegSet    = 4'h4,
    CondNegClr    = 4'h5,
    CondOvfSet    = 4'h6,
    CondOvfClr    = 4'h7,
    CondUHigher   = 4'h8,
    CondULowSame  = 4'h9,
    CondSGreatEq  = 4'hA,
    CondSLess     = 4'hB,
    CondSGreater  = 4'hC,
    CondSLessEq   = 4'hD,
    CondAlways    = 4'hE,
    CondNever     = 4'hF
  } cond_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flagLoad;
    logic [FLAG_W-1:0] fwdSel;
    logic              emit;
  } ctrl_strobe_t;

endpackage

// File: rtl/brc_cond_table.sv
module brc_cond_table
  import brc_pkg::*;
#(
  parameter int CW = COND_W
) (
  input  nzcv_t         flags,
  input  logic [CW-1:0] cond,
  output logic          condTaken
);

  localparam int NUM_COND = 1 << CW;
  localparam int NUM_BASE = NUM_COND / 2;

  logic [NUM_BASE-1:0] basePred;
  logic                signAgree;

  assign signAgree = (flags.n == flags.v);

  // Each even/odd code pair shares one base predicate; the low code bit inverts it.
  for (genvar g = 0; g < NUM_BASE; g++) begin : gBase
    if (g == 0) begin : gZ
      assign basePred[g] = flags.z;
    end else if (g == 1) begin : gC
      assign basePred[g] = flags.c;
    end else if (g == 2) begin : gN
      assign basePred[g] = flags.n;
    end else if (g == 3) begin : gV
      assign basePred[g] = flags.v;
    end else if (g == 4) begin : gHi
      assign basePred[g] = flags.c & ~flags.z;
    end else if (g == 5) begin : gGe
      assign basePred[g] = signAgree;
    end else if (g == 6) begin : gGt
      assign basePred[g] = ~flags.z & signAgree;
    end else begin : gAl
      assign basePred[g] = 1'b1;
    end
  end

  assign condTaken = basePred[cond[CW-1:1]] ^ cond[0];

endmodule

// File: rtl/brc_control.sv
module brc_control
  import brc_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic [FW-1:0] flagWe,
  input  logic          brValid,
  output ctrl_strobe_t  strobe
);

  always_comb begin
    strobe          = '0;
    strobe.flagLoad = flagWe;
    strobe.fwdSel   = flagWe;
    strobe.emit     = brValid;
  end

endmodule

// File: rtl/brc_datapath.sv
module brc_datapath
  import brc_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int CW = COND_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobe_t  strobe,
  input  logic [FW-1:0] flagIn,
  input  logic [CW-1:0] brCond,
  output logic          takenValid,
  output logic          taken
);

  logic [FW-1:0] flagsQ;
  logic [FW-1:0] effFlags;
  logic          condTaken;
  logic          validQ;
  logic          takenQ;

  for (genvar i = 0; i < FW; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    flagsQ[i] <= 1'b0;
      else if (strobe.flagLoad[i])  flagsQ[i] <= flagIn[i];
    end
    assign effFlags[i] = strobe.fwdSel[i] ? flagIn[i] : flagsQ[i];
  end

  brc_cond_table #(.CW(CW)) i_table (
    .flags     (nzcv_t'(effFlags)),
    .cond      (brCond),
    .condTaken (condTaken)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      takenQ <= 1'b0;
    end else begin
      validQ <= strobe.emit;
      takenQ <= strobe.emit & condTaken;
    end
  end

  assign takenValid = validQ;
  assign taken      = takenQ;

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  flagWe,
  input  logic [3:0]  flagIn,
  input  logic        brValid,
  input  logic [3:0]  brCond,
  output logic        takenValid,
  output logic        taken
);

  ctrl_strobe_t strobe;

  brc_control #(.FW(FLAG_W)) i_control (
    .flagWe  (flagWe),
    .brValid (brValid),
    .strobe  (strobe)
  );

  brc_datapath #(.FW(FLAG_W), .CW(COND_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .flagIn     (flagIn),
    .brCond     (brCond),
    .takenValid (takenValid),
    .taken      (taken)
  );

endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] flagWe,
  input logic [3:0] flagIn,
  input logic       brValid,
  input logic [3:0] brCond,
  input logic       takenValid,
  input logic       taken
);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!takenValid && !taken);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    brValid |=> takenValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |=> (!takenValid && !taken));

  a_r4_forward_zero: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && flagWe[2] && brCond == 4'h0) |=> (taken == $past(flagIn[2])));

  a_r8_forward_ge: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && flagWe[3] && flagWe[0] && brCond == 4'hA)
      |=> (taken == ($past(flagIn[3]) == $past(flagIn[0]))));

  a_r10_always: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brCond == 4'hE) |=> taken);

  a_r10_never: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brCond == 4'hF) |=> !taken);

endmodule

bind branch_resolver brc_checker i_chk (.*);

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] flagWe = '0;
  logic [3:0] flagIn = '0;
  logic       brValid = 1'b0;
  logic [3:0] brCond = '0;
  logic       takenValid;
  logic       taken;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  bit [3:0] mFlags  = '0;
  bit       expValid = 1'b0;
  bit       expTaken = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk(clk), .rstN(rstN), .flagWe(flagWe), .flagIn(flagIn),
    .brValid(brValid), .brCond(brCond),
    .takenValid(takenValid), .taken(taken)
  );

  function automatic bit refTaken(int code, bit [3:0] f);
    bit n = f[3];
    bit z = f[2];
    bit c = f[1];
    bit v = f[0];
    case (code)
      0: return z;
      1: return !z;
      2: return c;
      3: return !c;
      4: return n;
      5: return !n;
      6: return v;
      7: return !v;
      8: return c && !z;
      9: return !c || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string condTag(int code);
    if (code < 2) return "R5";
    if (code < 8) return "R6";
    if (code < 10) return "R7";
    if (code < 12) return "R8";
    if (code < 14) return "R9";
    return "R10";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // One clock: drive at negedge, update model, compare just after the edge.
  task automatic cyc(bit [3:0] we, bit [3:0] fi, bit bv, bit [3:0] bc, string tag);
    bit [3:0] eff;
    string t;
    @(negedge clk);
    flagWe = we; flagIn = fi; brValid = bv; brCond = bc;
    eff = (fi & we) | (mFlags & ~we);
    expValid = bv;
    expTaken = bv && refTaken(int'(bc), eff);
    mFlags = eff;
    @(posedge clk);
    #1;
    t = bv ? {tag, "/", condTag(int'(bc))} : tag;
    check("R2", "takenValid", int'(takenValid), int'(expValid));
    check(t, "taken", int'(taken), int'(expTaken));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "takenValid in reset", int'(takenValid), 0);
    check("R1", "taken in reset", int'(taken), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: flags start at zero
    cyc(4'h0, 4'h0, 1'b1, 4'h0, "R1");
    cyc(4'h0, 4'h0, 1'b1, 4'h1, "R1");
    cyc(4'h0, 4'h0, 1'b0, 4'h0, "R2");

    // Stored path: write all flags, branch next cycle
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        cyc(4'hF, 4'(f), 1'b0, 4'h0, "R3");
        cyc(4'h0, 4'h0, 1'b1, 4'(c), "R3");
      end
    end

    // R4: same-cycle write and branch
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        cyc(4'hF, 4'(f), 1'b1, 4'(c), "R4");
      end
    end

    // R3/R4: partial write masks with random traffic
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0], lfsr[7:4], lfsr[8] | lfsr[9], lfsr[15:12], "R3");
    end

    cyc(4'h0, 4'h0, 1'b0, 4'h0, "R2");
    done = 1'b1;
    summary();
  end

endmodule